// File: doc/BRIEF.md
# Keypad Code Capture for a Tone Dialer

This block sits between a microcontroller and a dual-tone generator. It takes a 4-bit tone-select code over one of two links. The parallel link uses four data pins. The serial link uses two pins: one data pin shared with parallel bit A, and the mode pin, which also acts as the shift clock. The block freezes the chosen code for the whole time a tone is sent.

The transmit-enable input is active low. A falling edge on it latches the code. The mode level at that moment picks the source:
- Mode high takes the parallel pins.
- Mode low takes the internal 4-stage shift register.

While enable stays low, the held code cannot change. The block raises a run-enable for the tone generator and pulls a tone-active flag low. The shift register keeps accepting bits during this time, so the next code can be loaded while the current tone plays.

When enable is high, the block is in standby. The run-enable is off, the code output reads zero and the flag driver is released. Every pin passes through a two-flop synchroniser. All synchroniser flops reset to 1, so an undriven input reads as 1.

Top module: `keycode_capture`

## Requirements
- R1: During and right after reset, code_o is 0, code_valid_o is 0, run_o is 0, flag_oe_o is 0 and flag_no is 1.
- R2: If mode_i is high when tx_en_ni falls, the captured code is {dat_a_i, dat_b_i, dat_c_i, dat_d_i}, with dat_a_i at code_o[3] and dat_d_i at code_o[0]. The code first shows on the third rising clock edge after the fall is sampled, and is not yet visible after the second.
- R3: Each rising edge of mode_i shifts dat_a_i into the shift register. Bits move from the A end toward the D end. After four shifts, the first bit entered sits at code_o[0] and the last at code_o[3]. If mode_i is low when tx_en_ni falls, this register is captured.
- R4: While tx_en_ni stays low, changes on mode_i or any data pin leave code_o unchanged.
- R5: Shifts made while tx_en_ni is low do take effect. A code shifted in during one active interval is captured at the next serial-mode falling edge.
- R6: Within three clock cycles of tx_en_ni going high, run_o is 0, flag_oe_o is 0, flag_no is 1 and code_o is 0. This holds for the whole standby period.
- R7: While active (tx_en_ni low, after the same three-cycle latency), run_o is 1, flag_oe_o is 1 and flag_no is 0.
- R8: code_valid_o pulses high for exactly one cycle per falling edge of tx_en_ni. The pulse comes in the cycle the new code first appears and run_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | High: parallel source; low: serial source; rising edge shifts |
| dat_a_i | input | 1 | Parallel bit A and serial data in |
| dat_b_i | input | 1 | Parallel bit B |
| dat_c_i | input | 1 | Parallel bit C |
| dat_d_i | input | 1 | Parallel bit D |
| tx_en_ni | input | 1 | Active-low transmit enable; falling edge latches code |
| code_o | output | 4 | Held code {A,B,C,D}; 0 in standby |
| code_valid_o | output | 1 | One-cycle strobe with a newly held code |
| run_o | output | 1 | Run-enable to the tone generator |
| flag_no | output | 1 | Tone-active flag, driven low while active |
| flag_oe_o | output | 1 | Drive enable of the flag, 0 means released |

## Verification
The first sign of a corrupt shift-register stage or a wrong bit order is a wrong code_o. It shows three cycles after the next serial-mode falling edge, and it shows even if that code was shifted in during an earlier tone. A holding register that leaks input changes shows up during an active interval, one cycle after a pin change passes the synchroniser. A wrong fall detector shows up within three cycles of the enable edge: the code_valid_o pulse goes missing or repeats, or the edge is seen at the wrong time.

// File: rtl/kc_pkg.sv
package kc_pkg;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned SYNC_W = CODE_W + 2;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/kc_sync.sv
module kc_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // reset to 1: undriven pins read high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/kc_shift.sv
module kc_shift #(
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             bit_i,
  output logic [DEPTH-1:0] q_o
);
  // q_o[DEPTH-1] is the A end, q_o[0] the D end
  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else if (step_i) sr_q <= {bit_i, sr_q[DEPTH-1:1]};
  end

  assign q_o = sr_q;
endmodule

// File: rtl/kc_hold.sv
module kc_hold #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             active_i,
  input  logic [WIDTH-1:0] code_i,
  output logic [WIDTH-1:0] code_o,
  output logic             valid_o,
  output logic             active_o
);
  logic [WIDTH-1:0] held_q;
  logic             valid_q;
  logic             active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q   <= '0;
      valid_q  <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (load_i) held_q <= code_i;
      valid_q  <= load_i;
      active_q <= active_i;
    end
  end

  assign code_o   = active_q ? held_q : '0;
  assign valid_o  = valid_q;
  assign active_o = active_q;
endmodule

// File: rtl/keycode_capture.sv
module keycode_capture
  import kc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              dat_a_i,
  input  logic              dat_b_i,
  input  logic              dat_c_i,
  input  logic              dat_d_i,
  input  logic              tx_en_ni,
  output logic [CODE_W-1:0] code_o,
  output logic              code_valid_o,
  output logic              run_o,
  output logic              flag_no,
  output logic              flag_oe_o
);
  logic [SYNC_W-1:0] raw, syn;
  logic              en_n_s, mode_s;
  code_t             par_s, ser_q, sel_code;
  logic              en_n_p, mode_p;
  logic              en_fall, mode_rise;
  logic              active;

  assign raw = {tx_en_ni, mode_i, dat_a_i, dat_b_i, dat_c_i, dat_d_i};

  kc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign en_n_s = syn[SYNC_W-1];
  assign mode_s = syn[SYNC_W-2];
  assign par_s  = syn[CODE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_n_p <= 1'b1;
      mode_p <= 1'b1;
    end else begin
      en_n_p <= en_n_s;
      mode_p <= mode_s;
    end
  end

  assign en_fall   = en_n_p & ~en_n_s;
  assign mode_rise = mode_s & ~mode_p;

  kc_shift #(.DEPTH(CODE_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(mode_rise),
    .bit_i (par_s[CODE_W-1]),
    .q_o   (ser_q)
  );

  assign sel_code = mode_s ? par_s : ser_q;

  kc_hold #(.WIDTH(CODE_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (en_fall),
    .active_i(~en_n_s),
    .code_i  (sel_code),
    .code_o  (code_o),
    .valid_o (code_valid_o),
    .active_o(active)
  );

  assign run_o     = active;
  assign flag_oe_o = active;
  assign flag_no   = ~active;
endmodule

// File: rtl/keycode_capture_chk.sv
module keycode_capture_chk
  import kc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] code_o,
  input logic              code_valid_o,
  input logic              run_o,
  input logic              flag_no,
  input logic              flag_oe_o
);
  // R8
  valid_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_o |=> !code_valid_o);

  // R8
  valid_with_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> code_valid_o);

  // R4
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && $past(run_o)) |-> $stable(code_o));

  // R6
  standby_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> (code_o == '0 && !flag_oe_o && flag_no && !code_valid_o));

  // R7
  active_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (flag_oe_o && !flag_no));
endmodule

bind keycode_capture keycode_capture_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .code_o      (code_o),
  .code_valid_o(code_valid_o),
  .run_o       (run_o),
  .flag_no     (flag_no),
  .flag_oe_o   (flag_oe_o)
);

// File: tb/keycode_capture_bench.sv
`timescale 1ns/1ps
module keycode_capture_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b1;
  logic       dat_a_i = 1'b1, dat_b_i = 1'b1, dat_c_i = 1'b1, dat_d_i = 1'b1;
  logic       tx_en_ni = 1'b1;
  logic [3:0] code_o;
  logic       code_valid_o, run_o, flag_no, flag_oe_o;

  int unsigned total = 0, bad = 0, strobes = 0, exp_strobes = 0;
  bit          done = 1'b0;
  logic [3:0]  exp_q[$];

  always #2.5 clk_i = ~clk_i;

  keycode_capture u_keycode_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .dat_a_i(dat_a_i), .dat_b_i(dat_b_i), .dat_c_i(dat_c_i), .dat_d_i(dat_d_i),
    .tx_en_ni(tx_en_ni), .code_o(code_o), .code_valid_o(code_valid_o),
    .run_o(run_o), .flag_no(flag_no), .flag_oe_o(flag_oe_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_par(input logic [3:0] c);
    @(negedge clk_i);
    {dat_a_i, dat_b_i, dat_c_i, dat_d_i} = c;
  endtask

  // first bit sent ends at code[0]
  task automatic shift_code(input logic [3:0] c);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      dat_a_i = c[i];
      wait_n(1);
      mode_i = 1'b1;
      wait_n(3);
      mode_i = 1'b0;
      wait_n(3);
    end
  endtask

  // driver: fall on enable, expected code pushed to scoreboard
  task automatic start_tx(input logic [3:0] c);
    exp_q.push_back(c);
    exp_strobes++;
    @(negedge clk_i);
    tx_en_ni = 1'b0;
  endtask

  task automatic stop_tx;
    @(negedge clk_i);
    tx_en_ni = 1'b1;
    wait_n(3);
    chk(!run_o && !flag_oe_o && flag_no && code_o == 4'h0, "R6 standby",
        {run_o, flag_oe_o, flag_no}, 3'b001);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && code_valid_o) begin
      strobes++;
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected strobe", code_o, 0);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk(code_o == e, "R8 strobe code", code_o, e);
        chk(run_o == 1'b1, "R8 strobe with run", run_o, 1);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    chk(code_o == 0 && !code_valid_o && !run_o && !flag_oe_o && flag_no,
        "R1 in reset", {code_o, run_o, flag_oe_o, flag_no}, 7'b0000001);
    @(negedge clk_i) rst_ni = 1'b1;
    wait_n(4);
    chk(code_o == 0 && !code_valid_o && !run_o && !flag_oe_o && flag_no,
        "R1 after reset", {code_o, run_o, flag_oe_o, flag_no}, 7'b0000001);

    // parallel pattern 0xA
    mode_i = 1'b1;
    set_par(4'hA);
    wait_n(3);
    start_tx(4'hA);
    wait_n(2);
    chk(!run_o && code_o == 4'h0, "R2 latency early", {run_o, code_o}, 0);
    wait_n(1);
    chk(code_o == 4'hA, "R2 parallel A", code_o, 4'hA);
    chk(run_o && flag_oe_o && !flag_no, "R7 active", {run_o, flag_oe_o, flag_no}, 3'b110);
    set_par(4'h5);
    mode_i = 1'b0;
    wait_n(6);
    chk(code_o == 4'hA, "R4 hold parallel", code_o, 4'hA);
    mode_i = 1'b1;
    stop_tx();

    // parallel 0x3 and 0xF
    set_par(4'h3);
    wait_n(3);
    start_tx(4'h3);
    wait_n(3);
    chk(code_o == 4'h3, "R2 parallel 3", code_o, 4'h3);
    stop_tx();
    set_par(4'hF);
    wait_n(3);
    start_tx(4'hF);
    wait_n(3);
    chk(code_o == 4'hF, "R2 parallel F", code_o, 4'hF);
    stop_tx();

    // serial 0x6
    @(negedge clk_i) mode_i = 1'b0;
    set_par(4'h0);
    shift_code(4'h6);
    start_tx(4'h6);
    wait_n(3);
    chk(code_o == 4'h6, "R3 serial 6", code_o, 4'h6);
    // load next code while active
    shift_code(4'h9);
    set_par(4'hC);
    wait_n(4);
    chk(code_o == 4'h6, "R4 hold during shift", code_o, 4'h6);
    stop_tx();
    start_tx(4'h9);
    wait_n(3);
    chk(code_o == 4'h9, "R5 shifted while active", code_o, 4'h9);
    stop_tx();

    // bit order: single 1 first lands at code[0]
    shift_code(4'h1);
    start_tx(4'h1);
    wait_n(3);
    chk(code_o == 4'h1, "R3 order first bit D", code_o, 4'h1);
    stop_tx();
    shift_code(4'h8);
    start_tx(4'h8);
    wait_n(3);
    chk(code_o == 4'h8, "R3 order last bit A", code_o, 4'h8);
    stop_tx();

    wait_n(4);
    chk(strobes == exp_strobes, "R8 strobe count", strobes, exp_strobes);
    chk(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule